// File: doc/BRIEF.md
# Two-Wire Serial Master Bit Engine

This block is the bit-level engine of a serial master that owns one clock output and one shared, bidirectional data line. On a send strobe it takes the master side of the line and transmits a start bit, then a variable number of payload bits taken from a 64-bit command word, most significant first. On a receive strobe it releases the line and clocks in a given number of bits, accumulating them into a received word. The line is active-low in both directions.

Each bit period is a low clock phase followed by a high clock phase, each `PHASE_CYC` system clocks long. Transmit data changes only at the start of the low phase, so it is settled well before the rising edge on which the far end samples. Receive data is sampled in the last system cycle of the high phase, so the far end has almost the whole period to drive it. Framing, checksums, addressing and response lengths belong to the logic around this engine.

Top module: `sbm_engine`

## Requirements
- R1: After reset `sclk_o` is 1, `sda_oe_o` is 0, `sda_o` is 1, `busy_o`, `done_o` and `err_o` are 0, and `rx_word_o` and `rx_bits_o` are 0.
- R2: A send of n bits (n ≥ 1) drives, at successive rising edges of `sclk_o`, a start bit as level 0 and then payload bits `cmd_i[n-1]` down to `cmd_i[0]`, each driven as its complement; `sda_oe_o` is 1 throughout the send.
- R3: Every bit period is `PHASE_CYC` system clocks with `sclk_o` low followed by `PHASE_CYC` with it high, and `sda_o` changes only in cycles where `sclk_o` is low.
- R4: After an accepted send strobe of n bits, `busy_o` is 1 for exactly 2·`PHASE_CYC`·(n+1) cycles; in the first cycle it is 0 again `done_o` is 1 for one cycle, `sclk_o` is 1 and `sda_oe_o` is 0.
- R5: A send with a bit count of 0 produces no clock edge, leaves `sda_oe_o` at 0, raises `err_o` for one cycle, and neither sets `busy_o` nor pulses `done_o`.
- R6: A receive of n bits (n ≥ 1) holds `sda_oe_o` at 0, samples `sda_i` in the last cycle of each high phase, stores the complement of each sample at bit 0 after shifting the word left by one, keeps `busy_o` for 2·`PHASE_CYC`·n cycles and then pulses `done_o` for one cycle.
- R7: Receives accumulate: `rx_word_o` becomes (old << n) | new bits and `rx_bits_o` grows by n; an accepted send clears both to 0.
- R8: A receive with a bit count of 0 pulses `done_o` in the next cycle without raising `busy_o` or toggling `sclk_o`, and leaves `rx_word_o` and `rx_bits_o` unchanged.
- R9: Bit counts above 64 are treated as 64.
- R10: Send and receive strobes that arrive while `busy_o` is 1 are ignored.
- R11: When both strobes arrive in the same idle cycle, the send is carried out and the receive is dropped.
- R12: A strobe in the cycle where `done_o` is 1 is accepted, since `busy_o` is already 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| send_i | input | 1 | Start a send (one-cycle strobe) |
| recv_i | input | 1 | Start a receive (one-cycle strobe) |
| cmd_i | input | 64 | Command word; payload sits in the low n bits |
| nbits_i | input | 7 | Bit count for the strobed operation |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when an operation completes |
| err_o | output | 1 | One-cycle pulse on a rejected zero-length send |
| rx_word_o | output | 64 | Accumulated received word |
| rx_bits_o | output | 8 | Accumulated received bit count |
| sclk_o | output | 1 | Serial clock to the line |
| sda_o | output | 1 | Data level driven onto the line |
| sda_oe_o | output | 1 | Data line drive enable |
| sda_i | input | 1 | Data level read from the line |

## Verification
Two request paths can collide in one cycle: a send strobe and a receive strobe may arrive together, and a new strobe may land in the very cycle the previous operation reports completion. The bench raises both strobes on one idle cycle and judges the outcome from the line enable and the clock count, which must match a send; it also issues a receive exactly in the cycle `done_o` is seen high and expects a full, correctly sampled receive to follow. A send strobe injected in the middle of a receive must leave the enable low and the receive length unchanged.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_TX   = 2'd1,
        MODE_RX   = 2'd2
    } sbm_mode_e;
endpackage

// File: rtl/sbm_phase_timer.sv
module sbm_phase_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic phase_end_o
);
    localparam int LIM = (PHASE_CYC < 1) ? 1 : PHASE_CYC;
    localparam int TW  = (LIM < 2) ? 1 : $clog2(LIM);

    logic [TW-1:0] cnt_d, cnt_q;
    logic          last;

    always_comb begin
        last  = (cnt_q == TW'(LIM - 1));
        cnt_d = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (last)
            cnt_d = '0;
        else
            cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign phase_end_o = run_i && last;

    // Counter never runs while idle: a phase always starts from zero (R3)
    assert_timer_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/sbm_line_drv.sv
module sbm_line_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic level_i,
    input  logic oe_set_i,
    input  logic oe_clr_i,
    output logic sda_o,
    output logic oe_o
);
    typedef struct packed {
        logic sda;
        logic oe;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        // only rewrite the output register when the level really changes
        if (load_i && (level_i != line_q.sda))
            line_d.sda = level_i;
        if (oe_set_i)
            line_d.oe = 1'b1;
        else if (oe_clr_i)
            line_d.oe = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '{sda: 1'b1, oe: 1'b0};
        else        line_q <= line_d;
    end

    assign sda_o = line_q.sda;
    assign oe_o  = line_q.oe;

    // Controller never asks to take and release the line at once (R2)
    assert_oe_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe_set_i && oe_clr_i));
endmodule

// File: rtl/sbm_rx_shift.sv
module sbm_rx_shift #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] word_o,
    output logic [CNT_W-1:0]  count_o
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [CNT_W-1:0]  count;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr_i) begin
            acc_d.word  = '0;
            acc_d.count = '0;
        end else if (shift_i) begin
            acc_d.word  = {acc_q.word[DATA_W-2:0], bit_i};
            acc_d.count = acc_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign word_o  = acc_q.word;
    assign count_o = acc_q.count;

    // New bit lands at the least significant end (R6)
    assert_shift_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clr_i) |=> (word_o[0] == $past(bit_i)));
    // Count grows by one per received bit (R7)
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clr_i) |=> (count_o == $past(count_o) + CNT_W'(1)));
endmodule

// File: rtl/sbm_engine.sv
module sbm_engine
    import sbm_pkg::*;
#(
    parameter int PHASE_CYC = 4,
    parameter int DATA_W    = 64,
    parameter int CNT_W     = $clog2(DATA_W + 1),
    parameter int RXC_W     = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_i,
    input  logic              recv_i,
    input  logic [DATA_W-1:0] cmd_i,
    input  logic [CNT_W-1:0]  nbits_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic [RXC_W-1:0]  rx_bits_o,
    output logic              sclk_o,
    output logic              sda_o,
    output logic              sda_oe_o,
    input  logic              sda_i
);
    localparam int LW = CNT_W + 1;

    typedef struct packed {
        sbm_mode_e         mode;
        logic              sclk;
        logic              start;
        logic [LW-1:0]     left;
        logic [DATA_W-1:0] tx;
        logic              done;
        logic              err;
    } eng_t;

    eng_t st_d, st_q;

    logic              phase_end;
    logic              ld_load, ld_level, oe_set, oe_clr;
    logic              rx_clr, rx_shift, rx_bit;
    logic [CNT_W-1:0]  n_sat;

    sbm_phase_timer #(.PHASE_CYC(PHASE_CYC)) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (st_q.mode != MODE_IDLE),
        .phase_end_o (phase_end)
    );

    sbm_line_drv line_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ld_load),
        .level_i  (ld_level),
        .oe_set_i (oe_set),
        .oe_clr_i (oe_clr),
        .sda_o    (sda_o),
        .oe_o     (sda_oe_o)
    );

    sbm_rx_shift #(.DATA_W(DATA_W), .CNT_W(RXC_W)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (rx_clr),
        .shift_i (rx_shift),
        .bit_i   (rx_bit),
        .word_o  (rx_word_o),
        .count_o (rx_bits_o)
    );

    always_comb begin
        n_sat    = (nbits_i > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : nbits_i;
        st_d     = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        ld_load  = 1'b0;
        ld_level = 1'b1;
        oe_set   = 1'b0;
        oe_clr   = 1'b0;
        rx_clr   = 1'b0;
        rx_shift = 1'b0;
        rx_bit   = ~sda_i;

        unique case (st_q.mode)
            MODE_IDLE: begin
                if (send_i) begin
                    if (n_sat == '0) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.mode  = MODE_TX;
                        st_d.sclk  = 1'b0;
                        st_d.start = 1'b1;
                        st_d.left  = LW'(n_sat) + LW'(1);
                        st_d.tx    = cmd_i << (DATA_W - int'(n_sat));
                        ld_load    = 1'b1;
                        ld_level   = 1'b0;          // start bit level
                        oe_set     = 1'b1;
                        rx_clr     = 1'b1;
                    end
                end else if (recv_i) begin
                    if (n_sat == '0) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.mode = MODE_RX;
                        st_d.sclk = 1'b0;
                        st_d.left = LW'(n_sat);
                        oe_clr    = 1'b1;
                    end
                end
            end
            MODE_TX: begin
                if (phase_end) begin
                    if (!st_q.sclk) begin
                        st_d.sclk = 1'b1;
                    end else if (st_q.left == LW'(1)) begin
                        st_d.mode = MODE_IDLE;
                        st_d.done = 1'b1;
                        oe_clr    = 1'b1;
                    end else begin
                        st_d.left = st_q.left - LW'(1);
                        st_d.sclk = 1'b0;
                        ld_load   = 1'b1;
                        if (st_q.start) begin
                            st_d.start = 1'b0;
                            ld_level   = ~st_q.tx[DATA_W-1];
                        end else begin
                            st_d.tx  = st_q.tx << 1;
                            ld_level = ~st_q.tx[DATA_W-2];
                        end
                    end
                end
            end
            MODE_RX: begin
                if (phase_end) begin
                    if (!st_q.sclk) begin
                        st_d.sclk = 1'b1;
                    end else begin
                        rx_shift = 1'b1;            // end of high phase
                        if (st_q.left == LW'(1)) begin
                            st_d.mode = MODE_IDLE;
                            st_d.done = 1'b1;
                        end else begin
                            st_d.left = st_q.left - LW'(1);
                            st_d.sclk = 1'b0;
                        end
                    end
                end
            end
            default: st_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mode  <= MODE_IDLE;
            st_q.sclk  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.mode != MODE_IDLE);
    assign done_o = st_q.done;
    assign err_o  = st_q.err;
    assign sclk_o = st_q.sclk;

    // Idle leaves the clock high and the line released (R1)
    assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sclk_o && !sda_oe_o));
    // Line data moves only while the clock is low (R3)
    assert_sda_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_o) |-> !sclk_o);
    // Completion pulse lasts a single cycle and never overlaps busy (R4)
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !$past(done_o)));
    // Rejected send never touches the line or the clock (R5)
    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && sclk_o && !sda_oe_o && !done_o));
    // Receive never drives the line (R6)
    assert_rx_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RX) |-> !sda_oe_o);
    // Send keeps the line driven (R2)
    assert_tx_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_TX) |-> sda_oe_o);
endmodule

// File: tb/sbm_engine_tb.sv
module sbm_engine_tb_top;
    localparam int P = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        send_i = 1'b0;
    logic        recv_i = 1'b0;
    logic [63:0] cmd_i = '0;
    logic [6:0]  nbits_i = '0;
    logic        sda_i = 1'b1;
    logic        busy_o, done_o, err_o, sclk_o, sda_o, sda_oe_o;
    logic [63:0] rx_word_o;
    logic [7:0]  rx_bits_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_word = '0;
    logic [7:0]  exp_bits = '0;

    always #10 clk = ~clk;   // 50 MHz

    sbm_engine #(.PHASE_CYC(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .send_i(send_i), .recv_i(recv_i),
        .cmd_i(cmd_i), .nbits_i(nbits_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .rx_word_o(rx_word_o), .rx_bits_o(rx_bits_o),
        .sclk_o(sclk_o), .sda_o(sda_o), .sda_oe_o(sda_oe_o), .sda_i(sda_i)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send: starts at current negedge, returns at the negedge where done should be 1
    task automatic do_send(input logic [63:0] cmd, input int n, input bit also_recv);
        int nn = (n > 64) ? 64 : n;
        int cnt = 0, rises = 0, bad = 0, badphase = 0, run = 0, oebad = 0;
        logic prev_s, prev_d;
        cmd_i = cmd; nbits_i = 7'(n); send_i = 1'b1; recv_i = also_recv;
        @(negedge clk);
        send_i = 1'b0; recv_i = 1'b0;
        prev_s = 1'b1; prev_d = sda_o;
        while (busy_o && cnt < 2000) begin
            if (prev_s != sclk_o) begin
                if (cnt > 0 && run != P) badphase++;
                run = 0;
            end
            if (!prev_s && sclk_o) begin
                logic e = (rises == 0) ? 1'b0 : ~cmd[nn - rises];
                if (sda_o !== e) bad++;
                rises++;
            end
            if (sda_o !== prev_d && sclk_o) badphase++;
            if (!sda_oe_o) oebad++;
            prev_s = sclk_o; prev_d = sda_o; run++; cnt++;
            @(negedge clk);
        end
        if (run != P) badphase++;
        chk(bad == 0 && rises == nbits_i_eff(nn), "R2 bits", 64'(bad), 0);
        chk(oebad == 0, "R2 enable", 64'(oebad), 0);
        chk(badphase == 0, "R3 phases", 64'(badphase), 0);
        chk(cnt == 2*P*(nn+1), "R4 busy length", 64'(cnt), 64'(2*P*(nn+1)));
        chk(done_o && sclk_o && !sda_oe_o, "R4 done", {61'd0, done_o, sclk_o, sda_oe_o}, 64'b110);
        chk(rx_bits_o == 0 && rx_word_o == 0, "R7 send clears", rx_word_o, 0);
        exp_word = '0; exp_bits = '0;
    endtask

    function automatic int nbits_i_eff(input int nn);
        return nn + 1;
    endfunction

    // Receive: same entry/exit convention; poke injects a send strobe mid-run
    task automatic do_recv(input logic [63:0] resp, input int n, input bit poke);
        int nn = (n > 64) ? 64 : n;
        int cnt = 0, falls = 0, oebad = 0;
        logic prev_s;
        sda_i = ~resp[nn-1];
        nbits_i = 7'(n); recv_i = 1'b1;
        prev_s = sclk_o;
        @(negedge clk);
        recv_i = 1'b0;
        while (busy_o && cnt < 2000) begin
            if (prev_s && !sclk_o) begin
                if (falls > 0 && falls < nn) sda_i = ~resp[nn-1-falls];
                falls++;
            end
            if (sda_oe_o) oebad++;
            send_i = (poke && cnt == 5);
            if (poke && cnt == 5) nbits_i = 7'd8;
            prev_s = sclk_o; cnt++;
            @(negedge clk);
        end
        send_i = 1'b0;
        exp_word = (nn == 64) ? resp : ((exp_word << nn) | (resp & ((64'd1 << nn) - 1)));
        exp_bits = exp_bits + 8'(nn);
        chk(oebad == 0, poke ? "R10 enable stays low" : "R6 released", 64'(oebad), 0);
        chk(cnt == 2*P*nn, poke ? "R10 length" : "R6 busy length", 64'(cnt), 64'(2*P*nn));
        chk(done_o, "R6 done", 64'(done_o), 1);
        chk(rx_word_o == exp_word, "R6 R7 word", rx_word_o, exp_word);
        chk(rx_bits_o == exp_bits, "R7 count", 64'(rx_bits_o), 64'(exp_bits));
        sda_i = 1'b1;
    endtask

    task automatic t_reset;
        chk(sclk_o && !sda_oe_o && sda_o && !busy_o && !done_o && !err_o,
            "R1 idle outputs", {58'd0, sclk_o, sda_oe_o, sda_o, busy_o, done_o, err_o}, 64'b101000);
        chk(rx_word_o == 0 && rx_bits_o == 0, "R1 rx cleared", rx_word_o, 0);
    endtask

    task automatic t_zero_send;
        nbits_i = '0; send_i = 1'b1;
        @(negedge clk); send_i = 1'b0;
        chk(err_o && !busy_o && !done_o && sclk_o && !sda_oe_o, "R5 rejected",
            {59'd0, err_o, busy_o, done_o, sclk_o, sda_oe_o}, 64'b10010);
        @(negedge clk);
        chk(!err_o && sclk_o, "R5 single pulse", 64'(err_o), 0);
    endtask

    task automatic t_zero_recv;
        nbits_i = '0; recv_i = 1'b1;
        @(negedge clk); recv_i = 1'b0;
        chk(done_o && !busy_o && sclk_o, "R8 immediate done", {61'd0, done_o, busy_o, sclk_o}, 64'b101);
        chk(rx_word_o == exp_word && rx_bits_o == exp_bits, "R8 unchanged", rx_word_o, exp_word);
        @(negedge clk);
        chk(!done_o, "R8 single pulse", 64'(done_o), 0);
    endtask

    initial begin
        #100000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        do_send(64'h0000_0000_0000_00B5, 8, 1'b0);            // R2 R4 short
        @(negedge clk);
        do_send(64'hFFFF_0000_0000_0F0F, 40, 1'b0);           // R3 runs of equal bits
        @(negedge clk);
        do_send(64'h8000_0000_0000_0001, 64, 1'b0);           // full width
        @(negedge clk);
        do_send(64'hDEAD_BEEF_1234_5678, 100, 1'b0);          // R9 saturation
        @(negedge clk);
        t_zero_send();                                        // R5
        do_recv(64'h0000_0000_0000_0A5C, 12, 1'b0);           // R6
        @(negedge clk);
        do_recv(64'h0000_0000_0000_0013, 5, 1'b0);            // R7 accumulate
        @(negedge clk);
        t_zero_recv();                                        // R8
        do_recv(64'h0000_0000_0000_00C3, 8, 1'b1);            // R10 send during receive
        @(negedge clk);
        do_send(64'h0000_0000_0000_0006, 3, 1'b1);            // R11 both strobes: send wins
        do_recv(64'h0000_0000_0000_0029, 6, 1'b0);            // R12 strobe in done cycle
        @(negedge clk);
        do_recv(64'h1357_9BDF_0246_8ACE, 90, 1'b0);           // R9 receive saturation
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule